// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by fetching descriptors from a two-level translation table that lives in memory. A client presents a virtual address together with the table base. The walker then issues one or two 32-bit word reads through a single-outstanding read port and reports the outcome. The outcome is a physical address, a fault flag and a code for the mapping size.

The first-level table holds 4096 word descriptors and is indexed by the top twelve address bits. A first-level descriptor is one of three things: a 1 MiB section that ends the walk, a pointer to a 256-entry second-level table, or a fault. A second-level descriptor is one of three things: a 4 KiB small page, a 64 KiB large page, or a fault. A large page is stored as sixteen identical second-level entries, so any of them gives the same translation. The walker keeps no cached entries: every request walks the table afresh. The memory may take any number of cycles to accept a read and any number of cycles to return it.

Top module: `xlat_walker`

## Requirements
- R1: While `busy` is low, a high `req_valid` is accepted on the clock edge, and `busy` is high from the next cycle through the cycle of the `done` pulse. A `req_valid` seen while `busy` is high is ignored and produces no extra result.
- R2: The first read goes to word address {base[31:14], va[31:20], 2'b00}. Table base bits [13:0] have no effect on the result.
- R3: A first-level descriptor whose bits [1:0] are 0 or 3 ends the walk with a fault after exactly one read.
- R4: A first-level descriptor whose bits [1:0] are 2 is a section. The walk ends after one read with phys = {desc[31:20], va[19:0]} and size code 0.
- R5: A first-level descriptor whose bits [1:0] are 1 starts a second read at {desc[31:10], va[19:12], 2'b00}. This walk always takes exactly two reads.
- R6: For a second-level descriptor, bits [1:0] = 0 is a fault, bits [1:0] = 1 is a large page, and bit 1 set (value 2 or 3) is a small page.
- R7: A large page gives phys = {desc[31:16], va[15:0]} and size code 1. Every address in the 64 KiB region translates through its replicated entries to the same page base.
- R8: A small page gives phys = {desc[31:12], va[11:0]} and size code 2.
- R9: A faulting walk reports `done_fault` = 1, `done_phys` = 0 and size code 3.
- R10: `done` is high for exactly one cycle. `busy` is low in the cycle after it. A request held high during the `done` cycle is accepted only on the edge after that low cycle.
- R11: A read request holds its address stable until `mem_rd_ready`. Any latency on accept or on response gives the same result. A `mem_rsp_valid` that arrives while no read is awaiting a response is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_tbase | input | 32 | First-level table base (16 KiB aligned; low bits ignored) |
| busy | output | 1 | Walk in progress, from acceptance through the done pulse |
| mem_rd_valid | output | 1 | Read request pending |
| mem_rd_ready | input | 1 | Memory accepts the pending read |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (descriptor word) |
| done | output | 1 | One-cycle completion pulse |
| done_phys | output | 32 | Translated physical address (0 on fault) |
| done_fault | output | 1 | Translation fault |
| done_size | output | 2 | Size code: 0 = 1 MiB, 1 = 64 KiB, 2 = 4 KiB, 3 = none |

## Verification
Two coincidences are provoked on purpose. In the first, a new request is held high through the cycle of the done pulse. The bench judges by cycle position: the request must not be taken in that cycle, `busy` must drop for one cycle, and the request must be taken on the edge that follows. In the second, a spurious response strobe carrying a fault-coded word is placed in a cycle where a read is still waiting to be accepted. The bench judges that case by comparing the reported translation against the value computed from the table contents.

// File: rtl/xw_pkg.sv
package xw_pkg;

    parameter int unsigned XW_AW       = 32;  // address and descriptor width
    parameter int unsigned XW_SECT_SH  = 20;  // 1 MiB section
    parameter int unsigned XW_LARGE_SH = 16;  // 64 KiB page
    parameter int unsigned XW_SMALL_SH = 12;  // 4 KiB page

    localparam logic [XW_AW-1:0] XW_ONES = {XW_AW{1'b1}};
    // first-level index -> byte offset mask (4096 words)
    localparam logic [XW_AW-1:0] XW_L1_OFS_MASK  = (XW_ONES >> XW_SECT_SH) << 2;
    // first-level table base alignment (16 KiB)
    localparam logic [XW_AW-1:0] XW_L1_BASE_MASK = XW_ONES << (XW_AW - XW_SECT_SH + 2);
    // second-level index -> byte offset mask (256 words)
    localparam logic [XW_AW-1:0] XW_L2_OFS_MASK  =
        (XW_ONES >> (XW_AW - (XW_SECT_SH - XW_SMALL_SH))) << 2;
    // second-level table base alignment (1 KiB)
    localparam logic [XW_AW-1:0] XW_L2_BASE_MASK = XW_ONES << (XW_SECT_SH - XW_SMALL_SH + 2);
    localparam logic [XW_AW-1:0] XW_SECT_MASK    = XW_ONES << XW_SECT_SH;
    localparam logic [XW_AW-1:0] XW_LARGE_MASK   = XW_ONES << XW_LARGE_SH;
    localparam logic [XW_AW-1:0] XW_SMALL_MASK   = XW_ONES << XW_SMALL_SH;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_READ, ST_L1_WAIT, ST_L2_READ, ST_L2_WAIT, ST_DONE
    } xw_state_e;

    typedef enum logic [1:0] {
        SZ_SECT  = 2'd0,
        SZ_LARGE = 2'd1,
        SZ_SMALL = 2'd2,
        SZ_NONE  = 2'd3
    } xw_size_e;

    typedef enum logic [1:0] {
        L1K_FAULT, L1K_SECT, L1K_TABLE
    } xw_l1_kind_e;

endpackage

// File: rtl/xw_l1_addr.sv
module xw_l1_addr
    import xw_pkg::*;
(
    input  logic [XW_AW-1:0] tbase,
    input  logic [XW_AW-1:0] vaddr,
    output logic [XW_AW-1:0] word_addr
);
    // base aligned to the table size, index scaled to a word offset
    always_comb begin
        word_addr = (tbase & XW_L1_BASE_MASK) |
                    ((vaddr >> (XW_SECT_SH - 2)) & XW_L1_OFS_MASK);
    end
endmodule

// File: rtl/xw_l1_dec.sv
module xw_l1_dec
    import xw_pkg::*;
(
    input  logic [XW_AW-1:0] desc,
    input  logic [XW_AW-1:0] vaddr,
    output xw_l1_kind_e      kind,
    output logic [XW_AW-1:0] sect_phys,
    output logic [XW_AW-1:0] l2_addr
);
    always_comb begin
        unique case (desc[1:0])
            2'd2:    kind = L1K_SECT;
            2'd1:    kind = L1K_TABLE;
            default: kind = L1K_FAULT;   // 0 and 3 both fault
        endcase
        sect_phys = (desc & XW_SECT_MASK) | (vaddr & ~XW_SECT_MASK);
        l2_addr   = (desc & XW_L2_BASE_MASK) |
                    ((vaddr >> (XW_SMALL_SH - 2)) & XW_L2_OFS_MASK);
    end
endmodule

// File: rtl/xw_l2_dec.sv
module xw_l2_dec
    import xw_pkg::*;
(
    input  logic [XW_AW-1:0] desc,
    input  logic [XW_AW-1:0] vaddr,
    output logic             fault,
    output xw_size_e         size,
    output logic [XW_AW-1:0] phys
);
    always_comb begin
        if (desc[1]) begin
            // small page: bit 1 alone decides
            fault = 1'b0;
            size  = SZ_SMALL;
            phys  = (desc & XW_SMALL_MASK) | (vaddr & ~XW_SMALL_MASK);
        end else if (desc[0]) begin
            fault = 1'b0;
            size  = SZ_LARGE;
            phys  = (desc & XW_LARGE_MASK) | (vaddr & ~XW_LARGE_MASK);
        end else begin
            fault = 1'b1;
            size  = SZ_NONE;
            phys  = '0;
        end
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [31:0] req_tbase,
    output logic        busy,
    output logic        mem_rd_valid,
    input  logic        mem_rd_ready,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        done,
    output logic [31:0] done_phys,
    output logic        done_fault,
    output logic [1:0]  done_size
);

    typedef struct packed {
        xw_state_e        st;
        logic [XW_AW-1:0] va;
        logic [XW_AW-1:0] rd_addr;
        logic [XW_AW-1:0] phys;
        logic             fault;
        xw_size_e         size;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic [XW_AW-1:0] l1_word_addr;
    xw_l1_kind_e      l1_kind;
    logic [XW_AW-1:0] l1_sect_phys;
    logic [XW_AW-1:0] l1_next_addr;
    logic             l2_fault;
    xw_size_e         l2_size;
    logic [XW_AW-1:0] l2_phys;

    xw_l1_addr i_l1_addr (
        .tbase     (req_tbase),
        .vaddr     (req_vaddr),
        .word_addr (l1_word_addr)
    );

    xw_l1_dec i_l1_dec (
        .desc      (mem_rsp_data),
        .vaddr     (walk_q.va),
        .kind      (l1_kind),
        .sect_phys (l1_sect_phys),
        .l2_addr   (l1_next_addr)
    );

    xw_l2_dec i_l2_dec (
        .desc  (mem_rsp_data),
        .vaddr (walk_q.va),
        .fault (l2_fault),
        .size  (l2_size),
        .phys  (l2_phys)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.va      = req_vaddr;
                    walk_d.rd_addr = l1_word_addr;
                    walk_d.st      = ST_L1_READ;
                end
            end
            ST_L1_READ: begin
                if (mem_rd_ready) walk_d.st = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (l1_kind)
                        L1K_SECT: begin
                            walk_d.phys  = l1_sect_phys;
                            walk_d.fault = 1'b0;
                            walk_d.size  = SZ_SECT;
                            walk_d.st    = ST_DONE;
                        end
                        L1K_TABLE: begin
                            walk_d.rd_addr = l1_next_addr;
                            walk_d.st      = ST_L2_READ;
                        end
                        default: begin
                            walk_d.phys  = '0;
                            walk_d.fault = 1'b1;
                            walk_d.size  = SZ_NONE;
                            walk_d.st    = ST_DONE;
                        end
                    endcase
                end
            end
            ST_L2_READ: begin
                if (mem_rd_ready) walk_d.st = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    walk_d.phys  = l2_phys;
                    walk_d.fault = l2_fault;
                    walk_d.size  = l2_size;
                    walk_d.st    = ST_DONE;
                end
            end
            ST_DONE: walk_d.st = ST_IDLE;
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy         = (walk_q.st != ST_IDLE);
    assign mem_rd_valid = (walk_q.st == ST_L1_READ) || (walk_q.st == ST_L2_READ);
    assign mem_rd_addr  = walk_q.rd_addr;
    assign done         = (walk_q.st == ST_DONE);
    assign done_phys    = walk_q.phys;
    assign done_fault   = walk_q.fault;
    assign done_size    = walk_q.size;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);                                   // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R10
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                                  // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R11
    AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_valid);                                         // R11
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (done_phys == '0 && done_size == 2'd3)); // R9

endmodule

// File: tb/test_xlat_walker.sv
module test_xlat_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_tbase = '0;
    logic        busy;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] done_phys;
    logic        done_fault;
    logic [1:0]  done_size;

    always #10 clk = ~clk;   // 50 MHz

    xlat_walker i_xlat_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_tbase(req_tbase),
        .busy(busy),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_phys(done_phys), .done_fault(done_fault), .done_size(done_size)
    );

    typedef struct {
        logic [31:0] phys;
        logic        fault;
        logic [1:0]  size;
        int          nr;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mem [logic [31:0]];
    int          n_checks = 0;
    int          n_errs = 0;
    int          nreads = 0;
    int          rdy_lat = 0;
    int          rsp_lat = 0;
    bit          stray_en = 1'b0;
    logic [31:0] rsp_addr;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model written from the requirements
    function automatic exp_t model(input logic [31:0] va, input logic [31:0] base);
        exp_t e;
        logic [31:0] d1, d2;
        d1 = rd({base[31:14], va[31:20], 2'b00});
        e.nr = 1; e.fault = 1'b0; e.phys = '0; e.size = 2'd3;
        if (d1[1:0] == 2'd2) begin
            e.phys = {d1[31:20], va[19:0]}; e.size = 2'd0; e.tag = "R4";
        end else if (d1[1:0] == 2'd1) begin
            e.nr = 2;
            d2 = rd({d1[31:10], va[19:12], 2'b00});
            if (d2[1]) begin
                e.phys = {d2[31:12], va[11:0]}; e.size = 2'd2; e.tag = "R8";
            end else if (d2[0]) begin
                e.phys = {d2[31:16], va[15:0]}; e.size = 2'd1; e.tag = "R7";
            end else begin
                e.fault = 1'b1; e.tag = "R6/R9";
            end
        end else begin
            e.fault = 1'b1; e.tag = "R3/R9";
        end
        return e;
    endfunction

    task automatic l1set(input logic [31:0] base, input logic [31:0] va, input logic [31:0] d);
        mem[{base[31:14], va[31:20], 2'b00}] = d;
    endtask

    task automatic l2set(input logic [31:0] l1d, input logic [31:0] va, input logic [31:0] d);
        mem[{l1d[31:10], va[19:12], 2'b00}] = d;
    endtask

    // driver: push expectation, issue request, wait for the walk to end
    task automatic xlate(input logic [31:0] va, input logic [31:0] base, input string note);
        exp_t e;
        e = model(va, base);
        e.tag = {e.tag, " ", note};
        sb.push_back(e);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_tbase = base;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // memory responder with programmable latency (R11)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_rd_valid) begin
                rsp_addr = mem_rd_addr;
                for (int i = 0; i < rdy_lat; i++) begin
                    if (stray_en && i == 0) begin
                        mem_rsp_valid = 1'b1;
                        mem_rsp_data  = 32'hFFFF_FFFF;
                    end
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                    check(mem_rd_valid && mem_rd_addr == rsp_addr, "R11 addr hold", mem_rd_addr, rsp_addr);
                end
                mem_rd_ready = 1'b1;
                nreads++;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                for (int i = 0; i < rsp_lat; i++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(rsp_addr);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // monitor: pop and compare on every done pulse
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1 unexpected result", done_phys, 32'h0);
                end else begin
                    e = sb.pop_front();
                    check(done_phys == e.phys && done_fault == e.fault && done_size == e.size,
                          e.tag, {done_phys[29:0], done_size}, {e.phys[29:0], e.size});
                    check(done_fault == e.fault, {e.tag, " fault"}, 32'(done_fault), 32'(e.fault));
                    check(nreads == e.nr, {e.tag, " read count R5"}, nreads, e.nr);
                end
                nreads = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [31:0] b0, l1p;
        b0  = 32'h0010_0000;
        l1p = 32'h0020_0401;
        // table contents
        l1set(b0, 32'h1234_5678, 32'hABC0_0002);
        l1set(b0, 32'h0340_0ABC, 32'h5550_0003);
        l1set(b0, 32'h4560_0000, l1p);
        l2set(l1p, 32'h4567_8123, 32'h7654_3002);
        l2set(l1p, 32'h4560_1FFF, 32'h1111_1003);
        for (int k = 0; k < 16; k++) l2set(l1p, 32'h4562_0000 + (k << 12), 32'h8888_0001);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_rd_valid, "R1 reset state", {busy, done, mem_rd_valid}, 32'h0);

        xlate(32'h1234_5678, b0, "section");                          // R4
        xlate(32'h1234_5678, 32'h0010_3FFC, "base low bits ignored R2");
        xlate(32'h0230_0000, b0, "type 0");                           // R3
        xlate(32'h0340_0ABC, b0, "type 3");                           // R3
        xlate(32'h4567_8123, b0, "small 2");                          // R8 R5
        xlate(32'h4560_1FFF, b0, "small 3 bit1");                     // R6
        xlate(32'h4562_0004, b0, "large first copy");                 // R7
        xlate(32'h4562_F00C, b0, "large last copy");                  // R7
        xlate(32'h456A_0000, b0, "l2 fault");                         // R6 R9

        // R11: latency and stray responses while a read waits for accept
        rdy_lat = 3; rsp_lat = 4; stray_en = 1'b1;
        xlate(32'h4567_8123, b0, "slow small R11");
        xlate(32'h1234_5678, b0, "slow section R11");
        rdy_lat = 0; rsp_lat = 0; stray_en = 1'b0;

        // R11: stray response while idle has no effect on the next walk
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0000_0002;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check(!busy, "R11 idle stray ignored", 32'(busy), 32'h0);
        xlate(32'h4562_0004, b0, "after idle stray R11");

        // R1: request while busy is ignored
        rdy_lat = 3;
        sb.push_back(model(32'h1234_5678, b0));
        req_valid = 1'b1; req_vaddr = 32'h1234_5678; req_tbase = b0;
        @(negedge clk);
        req_vaddr = 32'h0340_0ABC;        // still high while busy
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb.size() == 0 && !busy, "R1 busy request ignored", sb.size(), 0);
        rdy_lat = 0;

        // R10: request held through the done pulse
        sb.push_back(model(32'h1234_5678, b0));
        sb.push_back(model(32'h1234_5678, b0));
        req_valid = 1'b1; req_vaddr = 32'h1234_5678; req_tbase = b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        check(busy, "R10 busy during done", 32'(busy), 32'h1);
        @(negedge clk);
        check(!busy && !done, "R10 gap after done", {busy, done}, 32'h0);
        @(negedge clk);
        check(busy, "R10 held request taken after gap R1", 32'(busy), 32'h1);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R10 both results seen", sb.size(), 0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule